// File: doc/BRIEF.md
# Unaligned Four-Byte Text Fetch

This block returns any four consecutive bytes of a stored text in a single read access, whatever the alignment of the starting byte address. The text lives in four byte-wide banks that are interleaved by byte: the byte at address k sits in bank k mod 4, at word address k div 4. Any run of four consecutive bytes therefore touches every bank exactly once. For a read, the block gives each bank its own word address. It reads all four banks in the same cycle and then rotates the four bytes so the requested byte leads the returned word.

A scanning engine uses it to pull the block under its search window from any byte position in one cycle. A host loads the text beforehand through a byte-wide write port. The client chooses the addresses to fetch. The block only serves them.

Top module: `quad_fetch_top`

## Requirements
- R1: While reset is asserted and after it is released, `rd_valid` is 0 and `rd_data` is all zero until the first accepted read completes.
- R2: A host write with `wr_en` high stores `wr_byte` at byte address `wr_addr`, so a later read that covers that address returns the new value in the lane for that address. Writes to other addresses leave it unchanged.
- R3: A read at byte address A returns byte A in `rd_data[31:24]`, A+1 in `[23:16]`, A+2 in `[15:8]` and A+3 in `[7:0]`. This holds for each of the four values of A mod 4.
- R4: Byte addresses wrap modulo 2^ADDR_W. A read that starts in the last three bytes of the text continues from address 0.
- R5: A read is accepted when `rd_en` is high and `wr_en` is low. Its data and a one-cycle `rd_valid` pulse appear on the next clock edge. An accepted read may be issued in every cycle, and each one produces its own result.
- R6: When `wr_en` and `rd_en` are high in the same cycle, the write is performed, the read is dropped, and `rd_valid` stays low in the following cycle.
- R7: In a cycle after one with no accepted read, `rd_valid` is low and `rd_data` keeps the value of the last completed read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rd_en | input | 1 | Request a four-byte read |
| rd_addr | input | ADDR_W | Byte address of the first byte to return |
| rd_valid | output | 1 | Read data is present in this cycle |
| rd_data | output | 8*LANES | Fetched bytes, first byte in the most significant lane |
| wr_en | input | 1 | Host byte write strobe |
| wr_addr | input | ADDR_W | Byte address of the host write |
| wr_byte | input | 8 | Byte to store |

## Verification
The offset register and the per-bank address increments are state a client cannot see directly. A wrong value shows as bytes out of order or taken from the neighbouring word. This shows on `rd_data` in the cycle right after the read, and only for reads with a nonzero offset or reads near the top of memory. A stale offset paired with fresh bank data shows on the first back-to-back pair with different offsets, so the bench mixes offsets in consecutive cycles. A dropped or doubled valid pulse puts the scoreboard out of step at once.

// File: rtl/quad_fetch_pkg.sv
package quad_fetch_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/quad_fetch_addr.sv
module quad_fetch_addr
  import quad_fetch_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4
) (
  input  logic [ADDR_W-1:0]                          byte_addr,
  output logic [$clog2(LANES)-1:0]                   start_lane,
  output logic [LANES-1:0][ADDR_W-$clog2(LANES)-1:0] lane_addr
);
  localparam int OFS_W   = $clog2(LANES);
  localparam int WORD_AW = ADDR_W - OFS_W;

  logic [WORD_AW-1:0] base_word;

  assign base_word  = byte_addr[ADDR_W-1:OFS_W];
  assign start_lane = byte_addr[OFS_W-1:0];

  // Lanes below the start lane hold bytes that belong to the next word.
  for (genvar b = 0; b < LANES; b++) begin : g_lane
    logic bump;
    assign bump         = (OFS_W'(b) < start_lane);
    assign lane_addr[b] = base_word + {{(WORD_AW-1){1'b0}}, bump};
  end
endmodule

// File: rtl/quad_fetch_bank.sv
module quad_fetch_bank
  import quad_fetch_pkg::*;
#(
  parameter int WORD_AW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [WORD_AW-1:0] waddr,
  input  byte_t              wdata,
  input  logic               re,
  input  logic [WORD_AW-1:0] raddr,
  output byte_t              rdata
);
  localparam int DEPTH = 1 << WORD_AW;

  byte_t mem [DEPTH];
  byte_t rdata_q;
  byte_t rdata_nxt;

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_comb begin
    rdata_nxt = rdata_q;
    if (re) begin
      rdata_nxt = mem[raddr];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rdata_nxt;
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/quad_fetch_rotate.sv
module quad_fetch_rotate
  import quad_fetch_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic [$clog2(LANES)-1:0]   start_in,
  input  logic [LANES-1:0][BYTE_W-1:0] lanes_in,
  output logic [LANES*BYTE_W-1:0]    word_out
);
  localparam int OFS_W = $clog2(LANES);

  logic [OFS_W-1:0] start_q;
  logic [OFS_W-1:0] start_nxt;

  always_comb begin
    start_nxt = start_q;
    if (load) begin
      start_nxt = start_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
    end else begin
      start_q <= start_nxt;
    end
  end

  // Output position j (0 = first text byte) draws from lane start+j.
  for (genvar j = 0; j < LANES; j++) begin : g_pos
    logic [OFS_W-1:0] src;
    assign src = start_q + OFS_W'(j);
    assign word_out[(LANES-1-j)*BYTE_W +: BYTE_W] = lanes_in[src];
  end
endmodule

// File: rtl/quad_fetch_top.sv
module quad_fetch_top
  import quad_fetch_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic                    rd_valid,
  output logic [LANES*BYTE_W-1:0] rd_data,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [BYTE_W-1:0]       wr_byte
);
  localparam int OFS_W   = $clog2(LANES);
  localparam int WORD_AW = ADDR_W - OFS_W;

  logic                             rd_go;
  logic                             valid_q;
  logic                             valid_nxt;
  logic [OFS_W-1:0]                 start_lane;
  logic [LANES-1:0][WORD_AW-1:0]    lane_addr;
  logic [LANES-1:0][BYTE_W-1:0]     lane_data;
  logic [WORD_AW-1:0]               wr_word;
  logic [OFS_W-1:0]                 wr_lane;

  // The host write wins a same-cycle collision; the read is dropped.
  assign rd_go   = rd_en & ~wr_en;
  assign wr_word = wr_addr[ADDR_W-1:OFS_W];
  assign wr_lane = wr_addr[OFS_W-1:0];

  quad_fetch_addr #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES)
  ) u_addr (
    .byte_addr  (rd_addr),
    .start_lane (start_lane),
    .lane_addr  (lane_addr)
  );

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    logic bank_we;
    assign bank_we = wr_en & (wr_lane == OFS_W'(b));

    quad_fetch_bank #(
      .WORD_AW (WORD_AW)
    ) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (bank_we),
      .waddr (wr_word),
      .wdata (wr_byte),
      .re    (rd_go),
      .raddr (lane_addr[b]),
      .rdata (lane_data[b])
    );
  end

  quad_fetch_rotate #(
    .LANES (LANES)
  ) u_rot (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (rd_go),
    .start_in (start_lane),
    .lanes_in (lane_data),
    .word_out (rd_data)
  );

  always_comb begin
    valid_nxt = rd_go;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_nxt;
    end
  end

  assign rd_valid = valid_q;
endmodule

// File: rtl/quad_fetch_checker.sv
module quad_fetch_checker #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                rd_en,
  input logic                wr_en,
  input logic                rd_valid,
  input logic [LANES*8-1:0]  rd_data
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (!rd_valid && rd_data == '0));

  assert_read_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en) |=> rd_valid);

  assert_write_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !rd_valid);

  assert_no_spurious_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  assert_data_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && !wr_en) |=> $stable(rd_data));
endmodule

bind quad_fetch_top quad_fetch_checker #(
  .ADDR_W (ADDR_W),
  .LANES  (LANES)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_en    (rd_en),
  .wr_en    (wr_en),
  .rd_valid (rd_valid),
  .rd_data  (rd_data)
);

// File: tb/quad_fetch_top_tb.sv
module quad_fetch_top_tb;
  localparam int ADDR_W = 10;
  localparam int LANES  = 4;
  localparam int NBYTES = 1 << ADDR_W;

  logic              clk;
  logic              rst_n;
  logic              rd_en;
  logic [ADDR_W-1:0] rd_addr;
  logic              rd_valid;
  logic [31:0]       rd_data;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        wr_byte;

  logic [7:0]  model [NBYTES];
  logic [31:0] exp_q [$];
  string       tag_q [$];
  int          total = 0;
  int          bad   = 0;
  logic [31:0] last_word;
  bit          done  = 0;

  quad_fetch_top #(.ADDR_W(ADDR_W), .LANES(LANES)) u_dut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_byte(wr_byte)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] expect_word(int a);
    logic [31:0] w;
    for (int j = 0; j < 4; j++) begin
      w[(3-j)*8 +: 8] = model[(a + j) % NBYTES];
    end
    return w;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_byte(int a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_byte = d;
    model[a] = d;
    @(posedge clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic get_word(int a, string req);
    rd_en = 1'b1; rd_addr = ADDR_W'(a);
    exp_q.push_back(expect_word(a));
    tag_q.push_back(req);
    @(posedge clk); #2;
    rd_en = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(posedge clk);
    #2;
  endtask

  // Monitor: pops expected words as results appear.
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        check("R5 unexpected valid", 32'h1, 32'h0);
      end else begin
        check(tag_q.pop_front(), rd_data, exp_q.pop_front());
        last_word = rd_data;
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
    rd_addr = '0; wr_addr = '0; wr_byte = '0;
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    check("R1 valid", {31'd0, rd_valid}, 32'd0);
    check("R1 data", rd_data, 32'd0);
    rst_n = 1'b1;
    @(posedge clk); #2;
    check("R1 after release", {rd_data[30:0], rd_valid}, 32'd0);

    // R2: load the whole text
    for (int k = 0; k < NBYTES; k++) begin
      put_byte(k, 8'((k * 37) ^ (k >> 3) ^ 8'h5a));
    end

    // R3: every offset, isolated reads
    get_word(64, "R3 offset0"); @(posedge clk); #2;
    get_word(65, "R3 offset1"); @(posedge clk); #2;
    get_word(66, "R3 offset2"); @(posedge clk); #2;
    get_word(67, "R3 offset3"); @(posedge clk); #2;
    drain();

    // R5: back-to-back reads with changing offsets
    get_word(3, "R5 b2b");
    get_word(200, "R5 b2b");
    get_word(513, "R5 b2b");
    get_word(2, "R5 b2b");
    get_word(771, "R5 b2b");
    drain();

    // R4: wrap past the top
    get_word(NBYTES - 1, "R4 wrap3");
    get_word(NBYTES - 2, "R4 wrap2");
    get_word(NBYTES - 3, "R4 wrap1");
    get_word(NBYTES - 4, "R4 top aligned");
    drain();

    // R7: data holds while idle
    repeat (3) begin
      @(negedge clk);
      check("R7 hold data", rd_data, last_word);
      check("R7 valid low", {31'd0, rd_valid}, 32'd0);
    end
    @(posedge clk); #2;

    // R6: collision, write wins and read is dropped
    rd_en = 1'b1; rd_addr = ADDR_W'(300);
    wr_en = 1'b1; wr_addr = ADDR_W'(301); wr_byte = 8'hc3;
    model[301] = 8'hc3;
    @(posedge clk); #2;
    rd_en = 1'b0; wr_en = 1'b0;
    @(negedge clk);
    check("R6 no valid", {31'd0, rd_valid}, 32'd0);
    check("R6 data unchanged", rd_data, last_word);
    @(posedge clk); #2;
    get_word(300, "R6 write landed");
    drain();

    // R2: overwrite single bytes, neighbours kept
    put_byte(10, 8'h11);
    put_byte(13, 8'hee);
    get_word(9, "R2 overwrite");
    get_word(12, "R2 overwrite");
    get_word(10, "R2 overwrite");
    drain();
    repeat (2) @(posedge clk);
    #2;
    check("R5 queue empty", 32'(exp_q.size()), 32'd0);
    finish_run();
  end
endmodule